// File: doc/BRIEF.md
# Dual-Mode I2C SCL Clock Generator

This block produces the serial clock for an I2C master. Software supplies a 12-bit divider code `CC` split over two byte-wide registers, together with a mode bit that picks standard or fast timing. The generator then alternates a driven-low phase and a released phase on SCL. The low phase always opens a period. Each phase length is a linear function of `CC`, and the function differs between the two modes. In standard mode the duty cycle is close to even. In fast mode the released part is roughly a third of the period.

The generator also emits two single-cycle strobes for the byte engine. One falls mid-way through each low phase, which is where SDA may change. The other falls mid-way through each released phase, which is where SDA is sampled. While a slave holds SCL low during the released phase, the high-phase count pauses and a stretch flag is raised. Divider codes below 2 are refused: the generator parks with SCL released and raises an error flag. Start and stop conditions and byte sequencing are handled elsewhere.

The controller is built around five named states: `ST_IDLE`, `ST_LOW`, `ST_HIGH`, `ST_STRETCH` and `ST_ERR`. Its transitions are:

- start (`ST_IDLE` to `ST_LOW` or `ST_ERR`, when `run` rises)
- low_done (`ST_LOW` to `ST_HIGH`)
- hold_seen (`ST_HIGH` to `ST_STRETCH`)
- hold_gone (`ST_STRETCH` to `ST_HIGH`)
- boundary (`ST_HIGH` or `ST_STRETCH` to `ST_LOW` or `ST_ERR`)
- retry (`ST_ERR` to `ST_LOW`)
- halt (any state to `ST_IDLE`, when `run` is low)

Top module: `scl_clkgen`

## Requirements
- R1: After reset, SCL is released (`scl_drive_low`=0), and `cfg_err`, `stretch`, `tick_sda` and `tick_smp` are all 0.
- R2: The divider code is `CC = {ext_reg[4:0], ctl_reg[6:0]}`; bits 7:5 of `ext_reg` have no effect on timing.
- R3: With `ctl_reg[7]`=0 (standard mode), the low phase lasts `CC+3` clocks and the released phase `CC+2` clocks, so one period is `2*(CC-1)+7` clocks.
- R4: With `ctl_reg[7]`=1 (fast mode), the low phase lasts `2*CC+4` clocks and the released phase `CC+2` clocks, so one period is `3*(CC-1)+9` clocks.
- R5: A code `CC<2` loaded at a period boundary or at start raises `cfg_err` in the next cycle and keeps SCL released. Once the code is legal, a new low phase begins one cycle later and `cfg_err` drops.
- R6: During the released phase, each clock with `scl_in`=0 does not count toward the phase. That phase is lengthened by exactly that many clocks, and `stretch` is high for the same number of cycles, one cycle later.
- R7: Register writes take effect only at the next period boundary; the phases already under way keep their lengths.
- R8: `tick_sda` pulses exactly once in each low phase, and `tick_smp` exactly once in each released phase. Each pulse lasts one cycle, and neither appears in the other phase.
- R9: With `run`=0, SCL is released in the next cycle. When `run` rises with a legal code, SCL is driven low in the next cycle.
- R10: The largest code, `CC`=4095, gives a standard-mode low phase of 4098 clocks and a released phase of 4097 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run | input | 1 | Enables clock generation |
| ctl_reg | input | 8 | Bit 7: fast mode; bits 6:0: divider bits 6..0 |
| ext_reg | input | 8 | Bits 4:0: divider bits 11..7; bits 7:5 ignored |
| scl_in | input | 1 | Synchronized level of the SCL line |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| tick_sda | output | 1 | Mid-low strobe for SDA changes |
| tick_smp | output | 1 | Mid-high strobe for SDA sampling |
| stretch | output | 1 | A slave is holding SCL low in the released phase |
| cfg_err | output | 1 | Illegal divider code; SCL parked released |

## Verification
A corrupted phase counter or a wrong latched length appears at the ports as a low or released run of the wrong length on `scl_drive_low`. This shows up within the very phase that is affected. A missed or early reload at the boundary shows as a wrong run length in the first period after a register write. A lost stretch pause shows as a released run shorter than expected by the hold time, and as a `stretch` count that differs from the number of held cycles. A stuck state freezes SCL and stops the strobes. This is visible within one phase length, because the comparison against the expected run lengths then stalls.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LOW     = 3'd1,
        ST_HIGH    = 3'd2,
        ST_STRETCH = 3'd3,
        ST_ERR     = 3'd4
    } scl_state_t;

endpackage

// File: rtl/scl_div_decode.sv
module scl_div_decode #(
    parameter int REG_W = 8,
    parameter int DIV_W = 12,
    parameter int LO_W  = 7,
    parameter int CW    = DIV_W + 2
) (
    input  logic [REG_W-1:0] ctl,
    input  logic [REG_W-1:0] ext,
    output logic             cfg_ok,
    output logic [CW-1:0]    lo_len,
    output logic [CW-1:0]    hi_len
);
    localparam int HI_W = DIV_W - LO_W;

    logic [DIV_W-1:0] code;
    logic [CW-1:0]    code_x;
    logic             fast;
    logic             unused_ext;

    assign code       = {ext[HI_W-1:0], ctl[LO_W-1:0]};
    assign fast       = ctl[LO_W];
    assign code_x     = CW'(code);
    assign unused_ext = ^ext[REG_W-1:HI_W];

    // legal codes are 2 and above
    assign cfg_ok = (code > DIV_W'(1));

    // released phase is identical in both modes
    assign hi_len = code_x + CW'(2);

    // low phase: one extra clock in standard mode, twice the base in fast mode
    always_comb begin
        if (fast) lo_len = (code_x << 1) + CW'(4);
        else      lo_len = code_x + CW'(3);
    end

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_gen_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          scl_in,
    input  logic          cfg_ok,
    input  logic [CW-1:0] cfg_lo,
    input  logic [CW-1:0] cfg_hi,
    output scl_state_t    st,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] lat_lo,
    output logic [CW-1:0] lat_hi,
    output logic          drive_low,
    output logic          stretch,
    output logic          cfg_err
);
    localparam logic [CW-1:0] ONE  = CW'(1);
    localparam logic [CW-1:0] ZERO = '0;

    scl_state_t    st_n;
    logic [CW-1:0] cnt_n;
    logic          load;
    logic          take;

    // next state and counter
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        load  = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (run) load = 1'b1;
            end
            ST_LOW: begin
                if (cnt == ZERO) begin
                    st_n  = ST_HIGH;
                    cnt_n = lat_hi - ONE;
                end else begin
                    cnt_n = cnt - ONE;
                end
            end
            ST_HIGH: begin
                if (!scl_in)            st_n  = ST_STRETCH;
                else if (cnt == ZERO)   load  = 1'b1;
                else                    cnt_n = cnt - ONE;
            end
            ST_STRETCH: begin
                if (scl_in) begin
                    if (cnt == ZERO) begin
                        load = 1'b1;
                    end else begin
                        cnt_n = cnt - ONE;
                        st_n  = ST_HIGH;
                    end
                end
            end
            ST_ERR: begin
                load = 1'b1;
            end
            default: st_n = ST_IDLE;
        endcase
        if (load) begin
            if (cfg_ok) begin
                st_n  = ST_LOW;
                cnt_n = cfg_lo - ONE;
            end else begin
                st_n  = ST_ERR;
            end
        end
        if (!run) st_n = ST_IDLE;
    end

    assign take = load && cfg_ok && run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            cnt    <= ZERO;
            lat_lo <= ZERO;
            lat_hi <= ZERO;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
            if (take) begin
                lat_lo <= cfg_lo;
                lat_hi <= cfg_hi;
            end
        end
    end

    // outputs decoded from the registered state
    always_comb begin
        drive_low = (st == ST_LOW);
        stretch   = (st == ST_STRETCH);
        cfg_err   = (st == ST_ERR);
    end

    // low phase keeps going until its count is spent
    assert_low_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW && cnt != ZERO && run) |=> (st == ST_LOW));

    // a slave hold freezes the released-phase count
    assert_stretch_pause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STRETCH && !scl_in && run) |=> (st == ST_STRETCH && $stable(cnt)));

    // a legal code leaves the parked state at once
    assert_err_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_ERR && cfg_ok && run) |=> (st == ST_LOW));

    // latched lengths change only at a boundary
    assert_no_midphase_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_LOW) |=> ($stable(lat_lo) && $stable(lat_hi)));

    // dropping run releases the line on the next cycle
    assert_run_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !drive_low);

endmodule

// File: rtl/scl_tick_gen.sv
module scl_tick_gen
    import scl_gen_pkg::*;
#(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  scl_state_t    st,
    input  logic          scl_in,
    input  logic [CW-1:0] cnt,
    input  logic [CW-1:0] lat_lo,
    input  logic [CW-1:0] lat_hi,
    output logic          tick_sda,
    output logic          tick_smp
);
    logic [CW-1:0] mid_lo;
    logic [CW-1:0] mid_hi;
    logic          hi_counting;

    assign mid_lo      = lat_lo >> 1;
    assign mid_hi      = lat_hi >> 1;
    assign hi_counting = (st == ST_HIGH || st == ST_STRETCH) && scl_in;

    always_comb begin
        tick_sda = (st == ST_LOW) && (cnt == mid_lo);
        tick_smp = hi_counting && (cnt == mid_hi);
    end

    // each strobe lasts a single cycle
    assert_tick_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        tick_sda |=> !tick_sda);

endmodule

// File: rtl/scl_clkgen.sv
module scl_clkgen
    import scl_gen_pkg::*;
#(
    parameter int REG_W = 8,
    parameter int DIV_W = 12,
    parameter int LO_W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [REG_W-1:0] ctl_reg,
    input  logic [REG_W-1:0] ext_reg,
    input  logic             scl_in,
    output logic             scl_drive_low,
    output logic             tick_sda,
    output logic             tick_smp,
    output logic             stretch,
    output logic             cfg_err
);
    localparam int CW = DIV_W + 2;

    logic          cfg_ok;
    logic [CW-1:0] cfg_lo;
    logic [CW-1:0] cfg_hi;
    scl_state_t    st;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lat_lo;
    logic [CW-1:0] lat_hi;

    scl_div_decode #(
        .REG_W (REG_W),
        .DIV_W (DIV_W),
        .LO_W  (LO_W),
        .CW    (CW)
    ) u_dec (
        .ctl    (ctl_reg),
        .ext    (ext_reg),
        .cfg_ok (cfg_ok),
        .lo_len (cfg_lo),
        .hi_len (cfg_hi)
    );

    scl_phase_fsm #(.CW(CW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .scl_in    (scl_in),
        .cfg_ok    (cfg_ok),
        .cfg_lo    (cfg_lo),
        .cfg_hi    (cfg_hi),
        .st        (st),
        .cnt       (cnt),
        .lat_lo    (lat_lo),
        .lat_hi    (lat_hi),
        .drive_low (scl_drive_low),
        .stretch   (stretch),
        .cfg_err   (cfg_err)
    );

    scl_tick_gen #(.CW(CW)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .scl_in   (scl_in),
        .cnt      (cnt),
        .lat_lo   (lat_lo),
        .lat_hi   (lat_hi),
        .tick_sda (tick_sda),
        .tick_smp (tick_smp)
    );

endmodule

// File: tb/sim_scl_clkgen.sv
`timescale 1ns/100ps
module sim_scl_clkgen;
    logic       clk = 1'b0;
    logic       rst_n, run, hold;
    logic [7:0] ctl, ext;
    logic       drv, tsda, tsmp, strc, err;
    logic       scl_line;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    int    q_lvl[$];
    int    q_len[$];
    string q_tag[$];

    bit prev = 1'b0;
    int rlen = 0;
    int tk_ok = 0;
    int tk_bad = 0;
    int st_cnt = 0;

    always #2.5 clk = ~clk;

    assign scl_line = ~(drv | hold);

    scl_clkgen u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .run           (run),
        .ctl_reg       (ctl),
        .ext_reg       (ext),
        .scl_in        (scl_line),
        .scl_drive_low (drv),
        .tick_sda      (tsda),
        .tick_smp      (tsmp),
        .stretch       (strc),
        .cfg_err       (err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic push(input int lvl, input int len, input string tag);
        q_lvl.push_back(lvl);
        q_len.push_back(len);
        q_tag.push_back(tag);
    endtask

    task automatic push_periods(input int lo, input int hi, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            push(1, lo, tag);
            push(0, hi, tag);
        end
    endtask

    // compare one finished run of the SCL drive against the scoreboard
    task automatic finish_run(input bit lvl, input int len, input int good, input int bad);
        int    e_lvl, e_len;
        string e_tag;
        if (q_len.size() == 0) return;
        e_lvl = q_lvl.pop_front();
        e_len = q_len.pop_front();
        e_tag = q_tag.pop_front();
        if (e_len < 0) return;
        chk(int'(lvl) == e_lvl, e_tag, int'(lvl), e_lvl);
        chk(len == e_len, e_tag, len, e_len);
        chk(good == 1 && bad == 0, "R8", good * 10 + bad, 10);
    endtask

    // monitor: measures SCL drive runs and strobes
    always @(negedge clk) begin
        if (!rst_n) begin
            prev = 1'b0; rlen = 0; tk_ok = 0; tk_bad = 0;
        end else begin
            if (drv != prev) begin
                finish_run(prev, rlen, tk_ok, tk_bad);
                rlen = 0; tk_ok = 0; tk_bad = 0;
                prev = drv;
            end
            rlen++;
            if (drv) begin
                tk_ok += int'(tsda); tk_bad += int'(tsmp);
            end else begin
                tk_ok += int'(tsmp); tk_bad += int'(tsda);
            end
            if (strc) st_cnt++;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic drain();
        while (q_len.size() != 0) @(negedge clk);
    endtask

    task automatic stop_run();
        @(negedge clk); #1 run = 1'b0;
        @(negedge clk);
        chk(drv == 1'b0, "R9", int'(drv), 0);
        chk(err == 1'b0, "R9", int'(err), 0);
        repeat (2) @(negedge clk);
    endtask

    task automatic run_case(input logic [7:0] c, input logic [7:0] e,
                            input int lo, input int hi, input int n, input string tag);
        push(0, -1, tag);
        push_periods(lo, hi, n, tag);
        @(negedge clk); #1 ctl = c; ext = e; run = 1'b1;
        @(negedge clk);
        chk(drv == 1'b1, "R9", int'(drv), 1);
        drain();
        stop_run();
    endtask

    initial begin
        rst_n = 1'b0; run = 1'b0; hold = 1'b0; ctl = 8'h00; ext = 8'h00;
        repeat (4) @(negedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(drv == 1'b0, "R1", int'(drv), 0);
        chk(err == 1'b0, "R1", int'(err), 0);
        chk(strc == 1'b0, "R1", int'(strc), 0);
        chk(tsda == 1'b0 && tsmp == 1'b0, "R1", int'(tsda) + int'(tsmp), 0);

        // R5: illegal code at start, then recovery
        #1 ctl = 8'h01; ext = 8'h00; run = 1'b1;
        @(negedge clk);
        chk(err == 1'b1, "R5", int'(err), 1);
        chk(drv == 1'b0, "R5", int'(drv), 0);
        repeat (4) @(negedge clk);
        chk(err == 1'b1, "R5", int'(err), 1);
        push(0, -1, "R5");
        push_periods(5, 4, 2, "R3");
        #1 ctl = 8'h02;
        @(negedge clk);
        chk(drv == 1'b1, "R5", int'(drv), 1);
        chk(err == 1'b0, "R5", int'(err), 0);
        drain();
        stop_run();

        // R2: extension bits 7:5 ignored; extension bit 0 weighs 128
        run_case(8'h05, 8'hE0, 8, 7, 2, "R2");
        run_case(8'h00, 8'h01, 131, 130, 2, "R2");
        // R3: standard mode
        run_case(8'h0A, 8'h00, 13, 12, 2, "R3");
        // R4: fast mode, smallest and mid codes
        run_case(8'h82, 8'h00, 8, 4, 2, "R4");
        run_case(8'h8A, 8'h00, 24, 12, 2, "R4");
        // R10: largest code in both modes
        run_case(8'h7F, 8'h1F, 4098, 4097, 1, "R10");
        run_case(8'hFF, 8'h1F, 8194, 4097, 1, "R10");

        // R7: change during the first low phase applies after the boundary
        push(0, -1, "R7");
        push(1, 7, "R7");
        push(0, 6, "R7");
        push_periods(24, 12, 2, "R7");
        @(negedge clk); #1 ctl = 8'h04; ext = 8'h00; run = 1'b1;
        while (!drv) @(negedge clk);
        repeat (2) @(negedge clk);
        #1 ctl = 8'h8A;
        drain();
        stop_run();

        // R6: slave holds SCL for 5 clocks inside the released phase
        push(0, -1, "R6");
        push(1, 9, "R6");
        push(0, 13, "R6");
        push_periods(9, 8, 1, "R6");
        @(negedge clk); #1 ctl = 8'h06; ext = 8'h00; run = 1'b1;
        while (!drv) @(negedge clk);
        while (drv) @(negedge clk);
        repeat (2) @(negedge clk);
        st_cnt = 0;
        #1 hold = 1'b1;
        repeat (5) @(negedge clk);
        #1 hold = 1'b0;
        repeat (3) @(negedge clk);
        chk(st_cnt == 5, "R6", st_cnt, 5);
        drain();
        stop_run();

        // R5: illegal code written mid-run parks after the current period
        push(0, -1, "R5");
        push_periods(6, 5, 1, "R5");
        push(1, 6, "R5");
        @(negedge clk); #1 ctl = 8'h03; ext = 8'h00; run = 1'b1;
        while (q_len.size() > 1) @(negedge clk);
        #1 ctl = 8'h01;
        drain();
        repeat (12) @(negedge clk);
        chk(err == 1'b1, "R5", int'(err), 1);
        chk(drv == 1'b0, "R5", int'(drv), 0);
        push(0, -1, "R5");
        push_periods(6, 5, 1, "R5");
        #1 ctl = 8'h03;
        drain();
        stop_run();

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule